// File: doc/BRIEF.md
# Split-Write Dual DAC Code Register

This block is the digital front end for a pair of 12-bit digital-to-analog converters. Software reaches it over an 8-bit register bus. Each converter code is too wide for a single bus write, so every channel has two addresses: one for the upper 4 bits and one for the lower 8 bits. A write to the upper address only stages the nibble in a shadow register. A write to the lower address joins that staged nibble with the written byte and moves all 12 bits into the active code in one clock. The converter therefore never sees a new upper nibble paired with an old lower byte.

Software must write the upper part first and the lower part second. Each commit raises a one-cycle update strobe for that channel, in the same cycle as the new code appears. Reads return the halves of the active code, so a staged nibble stays invisible until it is committed. The channel count and code width are parameters. The defaults are two channels of 12 bits.

Top module: `dac_split_write`

## Requirements
- R1: While `rst_n` is low, and after it rises, every active code, every shadow nibble and every update strobe is zero.
- R2: A write to an upper address (bus address 2*ch+1) changes no active code and raises no update strobe.
- R3: A write of byte B to a lower address (bus address 2*ch) makes that channel's code equal {shadow nibble, B} on the next clock edge. All 12 bits change at that one edge, and that channel's `dac_upd` bit is high for exactly that one cycle.
- R4: A lower-address write that has no new upper write before it reuses the most recently staged nibble. The shadow keeps its value across commits.
- R5: On an upper-address write only data bits 3:0 are kept and bits 7:4 are ignored. A read of an upper address returns zero in bits 7:4.
- R6: `bus_rdata` is combinational from `bus_addr`. A lower address returns active code bits 7:0, and an upper address returns {4'b0, active code bits 11:8}. A staged but uncommitted nibble is never returned. A read in the same cycle as a write to that register returns the value from before the write.
- R7: A write to one channel leaves every other channel's code, shadow and strobe unchanged, and at most one `dac_upd` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write enable for the current bus cycle |
| bus_addr | input | ADDR_W (2) | Register address: bits above 0 select the channel, bit 0 selects the upper half |
| bus_wdata | input | BUS_W (8) | Write data |
| bus_rdata | output | BUS_W (8) | Read data for `bus_addr`, combinational |
| dac_code | output | NUM_CH*CODE_W (24) | Active codes, channel c at bits c*CODE_W and up |
| dac_upd | output | NUM_CH (2) | One-cycle commit strobe per channel |

## Verification
Two functions can fall in the same cycle: reading a register back and committing a new code into that same register, since a single address serves both. The bench drives a lower-address write and samples `bus_rdata` before the clock edge. The value must be the old byte, and the new byte must appear after the edge, together with the strobe. A full sweep of every nibble and byte on each channel also judges staging, commit and channel isolation against an arithmetic model.

// File: rtl/dac_sw_pkg.sv
package dac_sw_pkg;
    localparam int DEF_NUM_CH = 2;
    localparam int DEF_CODE_W = 12;
    localparam int DEF_BUS_W  = 8;
endpackage

// File: rtl/dac_sw_decode.sv
module dac_sw_decode #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] wr_lo,
    output logic [NUM_CH-1:0] wr_hi
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit      = (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'(c));
        assign wr_lo[c] = bus_wr && hit && !bus_addr[0];
        assign wr_hi[c] = bus_wr && hit &&  bus_addr[0];
    end
endmodule

// File: rtl/dac_sw_chan.sv
module dac_sw_chan #(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CODE_W-1:0] code,
    output logic              upd
);
    localparam int HI_W = CODE_W - BUS_W;

    typedef struct packed {
        logic [HI_W-1:0]   shadow;
        logic [CODE_W-1:0] code;
        logic              upd;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (wr_hi) begin
            st_d.shadow = wdata[HI_W-1:0];
        end
        if (wr_lo) begin
            st_d.code = {st_q.shadow, wdata};
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;
    assign upd  = st_q.upd;
endmodule

// File: rtl/dac_sw_rdmux.sv
module dac_sw_rdmux #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [NUM_CH*CODE_W-1:0] codes,
    output logic [BUS_W-1:0]         rdata
);
    localparam int HI_W = CODE_W - BUS_W;

    logic [CODE_W-1:0] sel_code;
    logic [ADDR_W-2:0] ch;

    always_comb begin
        ch       = bus_addr[ADDR_W-1:1];
        sel_code = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch == (ADDR_W-1)'(c)) begin
                sel_code = codes[c*CODE_W +: CODE_W];
            end
        end
        if (bus_addr[0]) begin
            rdata = {{(BUS_W-HI_W){1'b0}}, sel_code[CODE_W-1:BUS_W]};
        end else begin
            rdata = sel_code[BUS_W-1:0];
        end
    end
endmodule

// File: rtl/dac_split_write.sv
module dac_split_write #(
    parameter int NUM_CH = dac_sw_pkg::DEF_NUM_CH,
    parameter int CODE_W = dac_sw_pkg::DEF_CODE_W,
    parameter int BUS_W  = dac_sw_pkg::DEF_BUS_W,
    localparam int ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_upd
);
    logic [NUM_CH-1:0] wr_lo;
    logic [NUM_CH-1:0] wr_hi;

    dac_sw_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_sw_chan #(.CODE_W(CODE_W), .BUS_W(BUS_W)) chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr_lo[c]),
            .wr_hi (wr_hi[c]),
            .wdata (bus_wdata),
            .code  (dac_code[c*CODE_W +: CODE_W]),
            .upd   (dac_upd[c])
        );
    end

    dac_sw_rdmux #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
    ) rd_i (
        .bus_addr (bus_addr),
        .codes    (dac_code),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/dac_split_write_chk.sv
module dac_split_write_chk #(
    parameter int NUM_CH = 2,
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [BUS_W-1:0]         bus_wdata,
    input logic [BUS_W-1:0]         bus_rdata,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_upd
);
    localparam int HI_W = CODE_W - BUS_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (dac_code == '0 && dac_upd == '0));

    assert_hi_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |=> ($stable(dac_code) && dac_upd == '0));

    assert_rd_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> (bus_rdata[BUS_W-1:HI_W] == '0));

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dac_upd));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_commit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(2*c))
            |=> (dac_upd[c] && dac_code[c*CODE_W +: BUS_W] == $past(bus_wdata)));

        assert_change_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(dac_code[c*CODE_W +: CODE_W]) |-> dac_upd[c]);

        assert_other_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr[ADDR_W-1:1] != (ADDR_W-1)'(c))
            |=> ($stable(dac_code[c*CODE_W +: CODE_W]) && !dac_upd[c]));
    end
endmodule

bind dac_split_write dac_split_write_chk #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dac_code  (dac_code),
    .dac_upd   (dac_upd)
);

// File: tb/dac_split_write_tb_top.sv
`timescale 1ns/1ps
module dac_split_write_tb_top;
    localparam int NCH = 2;
    localparam int CW  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] dac_code;
    logic [1:0]  dac_upd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [11:0] exp_code [NCH];
    logic [3:0]  exp_sh   [NCH];

    always #4 clk = ~clk;

    dac_split_write dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dac_code(dac_code), .dac_upd(dac_upd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req);
        for (int c = 0; c < NCH; c++) begin
            check(dac_code[c*CW +: CW] == exp_code[c], req,
                  int'(dac_code[c*CW +: CW]), int'(exp_code[c]));
        end
    endtask

    // drive one write at a falling edge; returns at the next falling edge
    task automatic wr_op(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
    endtask

    task automatic commit(input int c, input logic [7:0] lo);
        wr_op(2'(2*c), lo);
        exp_code[c] = {exp_sh[c], lo};
        check_codes("R3/R7 commit code");
        check(dac_upd == 2'(1 << c), "R3/R7 strobe", int'(dac_upd), 1 << c);
        @(negedge clk);
        check(dac_upd == 2'b00, "R3 strobe one cycle", int'(dac_upd), 0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_code[c] = '0;
            exp_sh[c]   = '0;
        end
        repeat (3) @(negedge clk);
        check(dac_code == '0 && dac_upd == '0, "R1 in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_codes("R1 after reset");
        check(dac_upd == '0, "R1 strobe after reset", int'(dac_upd), 0);
        rd_chk(2'd1, 8'h00, "R1 read");

        // exhaustive sweep over every nibble and byte of each channel
        for (int c = 0; c < NCH; c++) begin
            for (int hi = 0; hi < 16; hi++) begin
                logic [7:0] hd;
                hd = {~4'(hi), 4'(hi)};
                wr_op(2'(2*c + 1), hd);
                exp_sh[c] = 4'(hi);
                check_codes("R2 upper write stages only");
                check(dac_upd == '0, "R2 no strobe", int'(dac_upd), 0);
                rd_chk(2'(2*c + 1), {4'h0, exp_code[c][11:8]}, "R6 staged invisible");
                for (int lo = 0; lo < 256; lo++) begin
                    commit(c, 8'(lo));
                end
                rd_chk(2'(2*c + 1), {4'h0, 4'(hi)}, "R5 upper read pads zero");
                rd_chk(2'(2*c), 8'hFF, "R6 lower read");
            end
        end

        // reuse of the staged nibble without a new upper write
        wr_op(2'd1, 8'hF9);
        exp_sh[0] = 4'h9;
        commit(0, 8'h12);
        commit(0, 8'h34);
        check(dac_code[11:8] == 4'h9, "R4 nibble reused", int'(dac_code[11:8]), 9);

        // read and commit of the same register in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hA5;
        #1;
        check(bus_rdata == exp_code[1][7:0], "R6 same-cycle read old",
              int'(bus_rdata), int'(exp_code[1][7:0]));
        @(negedge clk);
        bus_wr = 1'b0;
        exp_code[1] = {exp_sh[1], 8'hA5};
        #1;
        check(bus_rdata == 8'hA5, "R6 read after commit", int'(bus_rdata), 8'hA5);
        check_codes("R7 same-cycle commit codes");

        // reset mid-run clears shadows too
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            exp_code[c] = '0;
            exp_sh[c]   = '0;
        end
        check_codes("R1 mid-run reset");
        rst_n = 1'b1;
        commit(1, 8'h7E);
        check(dac_code[23:20] == 4'h0, "R1 shadow cleared", int'(dac_code[23:20]), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule